// File: doc/BRIEF.md
# Truncating Binary64 Multiplier

This block multiplies two double-precision operands for a small, low-cost floating-point unit. It trades exactness for area. Subnormal inputs are treated as zero, and results too small for a normal number are flushed to zero. Infinity is not a class of its own: any operand with an all-ones exponent is treated as not-a-number. The only exceptional output is one canonical quiet NaN, with sign 0, exponent all ones and fraction MSB set (0x7FF8000000000000).

An operation is launched by pulsing `start` with both operands valid. The product appears on `result` together with a one-cycle `done` pulse two clock cycles later. A new operation may be launched every cycle. The significand product keeps only its upper 68 bits. The fraction is cut toward zero, with no rounding increment. Renormalization is at most a single one-bit right shift.

Top module: `fmul_trunc64`

## Requirements
- R1: When `start` is high at a rising edge, `done` is high for exactly the clock cycle that follows the second rising edge after it. Back-to-back starts give back-to-back `done` pulses. `result` changes only together with a `done` pulse and otherwise holds its value.
- R2: If either operand has an exponent field of all ones (bits 62..52 = 0x7FF), whatever its fraction and sign, the result is 0x7FF8000000000000. This takes precedence over the zero rule.
- R3: Otherwise, if either operand has an exponent field of zero (true zero or subnormal, either sign), the result is 0x0000000000000000.
- R4: For two normal operands giving a normal result, the result sign (bit 63) is the XOR of the operand signs.
- R5: Let 1.fa × 1.fb lie in [1,2). Then the result exponent field is ea + eb − 1023, and the fraction is bits 103..52 of the 106-bit product of the two 53-bit significands.
- R6: Let the significand product lie in [2,4). Then it is shifted right by one bit. The result exponent field is ea + eb − 1022, and the fraction is product bits 104..53.
- R7: Product bits below the kept fraction never change the result. The fraction is truncated toward zero, with no rounding.
- R8: A computed result exponent of 0 or below gives 0x0000000000000000, never a subnormal or a negative zero.
- R9: A computed result exponent of 2047 or above gives 0x7FF8000000000000.
- R10: While and after reset, until the first completed operation, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch an operation with the current operands |
| op_a | input | 64 | First operand, Binary64 |
| op_b | input | 64 | Second operand, Binary64 |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 64 | Product, Binary64 |

## Verification
Every internal state of the block lives in a two-register pipeline, so any wrong value shows at `result` or `done` no later than two cycles after the operation that caused it. A misrouted class bit turns a product into the canonical NaN or into positive zero. An exponent sum that is off by one moves the result by a factor of two, or shifts where the underflow and overflow limits fall. A wrong normalization choice shifts the fraction by one place. A lost or extra valid bit shows as a missing `done` pulse, an extra one, or a late one.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    // Operand class after the cheap special-value decode
    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_NAN  = 2'd2
    } cls_e;

    localparam int DEF_EXP_W  = 11;
    localparam int DEF_FRAC_W = 52;
    localparam int DEF_KEEP_W = 68;

endpackage

// File: rtl/fmul_classify.sv
module fmul_classify
    import fmul_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output cls_e                  cls,
    output logic                  sgn,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W-1:0]     frac
);

    always_comb begin
        sgn  = op[EXP_W+FRAC_W];
        expo = op[EXP_W+FRAC_W-1:FRAC_W];
        frac = op[FRAC_W-1:0];
        if (&expo) begin
            cls = CLS_NAN;
        end else if (expo == '0) begin
            cls = CLS_ZERO;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fmul_sigmul.sv
module fmul_sigmul #(
    parameter int SIG_W  = 53,
    parameter int KEEP_W = 68
) (
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic [KEEP_W-1:0] keep
);

    localparam int PROD_W = 2 * SIG_W;
    localparam int DROP_W = PROD_W - KEEP_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(sig_a) * PROD_W'(sig_b);
        keep = KEEP_W'(prod >> DROP_W);
    end

endmodule

// File: rtl/fmul_pack.sv
module fmul_pack
    import fmul_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int KEEP_W = DEF_KEEP_W
) (
    input  cls_e                  cls,
    input  logic                  sgn,
    input  logic [EXP_W:0]        esum,
    input  logic [KEEP_W-1:0]     keep,
    output logic [EXP_W+FRAC_W:0] word
);

    localparam int EW2       = EXP_W + 2;
    localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX      = (1 << EXP_W) - 1;
    localparam int SHIFT_OUT = KEEP_W - 1 - FRAC_W;
    localparam logic signed [EW2-1:0] EMAX_S = EW2'(EMAX);
    localparam logic signed [EW2-1:0] ZERO_S = '0;
    localparam logic [EXP_W+FRAC_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic                    top;
    logic [KEEP_W-1:0]       norm;
    logic [FRAC_W-1:0]       frac;
    logic signed [EW2-1:0]   e_adj;

    always_comb begin
        top   = keep[KEEP_W-1];
        norm  = top ? keep : (keep << 1);
        frac  = FRAC_W'(norm >> SHIFT_OUT);
        e_adj = signed'({1'b0, esum}) - EW2'(BIAS) + EW2'(top);
        case (cls)
            CLS_NAN:  word = QNAN;
            CLS_ZERO: word = '0;
            default: begin
                if (e_adj <= ZERO_S) begin
                    word = '0;
                end else if (e_adj >= EMAX_S) begin
                    word = QNAN;
                end else begin
                    word = {sgn, EXP_W'(e_adj), frac};
                end
            end
        endcase
    end

endmodule

// File: rtl/fmul_trunc64.sv
module fmul_trunc64
    import fmul_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int KEEP_W = DEF_KEEP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic                  done,
    output logic [EXP_W+FRAC_W:0] result
);

    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int N_OPS  = 2;

    typedef struct packed {
        cls_e              cls;
        logic              sgn;
        logic [EXP_W:0]    esum;
        logic [KEEP_W-1:0] keep;
    } mid_t;

    typedef struct packed {
        logic              mid_vld;
        mid_t              mid;
        logic              done;
        logic [WORD_W-1:0] res;
    } state_t;

    logic [WORD_W-1:0] ops  [N_OPS];
    cls_e              cls  [N_OPS];
    logic              sgn  [N_OPS];
    logic [EXP_W-1:0]  expo [N_OPS];
    logic [FRAC_W-1:0] frac [N_OPS];

    logic [KEEP_W-1:0] keep;
    logic [WORD_W-1:0] packed_word;
    state_t            state_d, state_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fmul_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) cls_i (
            .op   (ops[i]),
            .cls  (cls[i]),
            .sgn  (sgn[i]),
            .expo (expo[i]),
            .frac (frac[i])
        );
    end

    fmul_sigmul #(
        .SIG_W  (SIG_W),
        .KEEP_W (KEEP_W)
    ) mul_i (
        .sig_a ({1'b1, frac[0]}),
        .sig_b ({1'b1, frac[1]}),
        .keep  (keep)
    );

    fmul_pack #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .KEEP_W (KEEP_W)
    ) pack_i (
        .cls  (state_q.mid.cls),
        .sgn  (state_q.mid.sgn),
        .esum (state_q.mid.esum),
        .keep (state_q.mid.keep),
        .word (packed_word)
    );

    always_comb begin
        state_d         = state_q;
        state_d.mid_vld = start;
        if (start) begin
            if (cls[0] == CLS_NAN || cls[1] == CLS_NAN) begin
                state_d.mid.cls = CLS_NAN;
            end else if (cls[0] == CLS_ZERO || cls[1] == CLS_ZERO) begin
                state_d.mid.cls = CLS_ZERO;
            end else begin
                state_d.mid.cls = CLS_NORM;
            end
            state_d.mid.sgn  = sgn[0] ^ sgn[1];
            state_d.mid.esum = {1'b0, expo[0]} + {1'b0, expo[1]};
            state_d.mid.keep = keep;
        end
        state_d.done = state_q.mid_vld;
        if (state_q.mid_vld) begin
            state_d.res = packed_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign done   = state_q.done;
    assign result = state_q.res;

endmodule

// File: rtl/fmul_trunc64_chk.sv
module fmul_trunc64_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [EXP_W+FRAC_W:0] op_a,
    input logic [EXP_W+FRAC_W:0] op_b,
    input logic                  done,
    input logic [EXP_W+FRAC_W:0] result
);

    localparam logic [EXP_W+FRAC_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic a_nan, b_nan, a_zero, b_zero, any_nan, any_zero;
    logic [EXP_W-1:0] res_exp;

    assign a_nan    = &op_a[EXP_W+FRAC_W-1:FRAC_W];
    assign b_nan    = &op_b[EXP_W+FRAC_W-1:FRAC_W];
    assign a_zero   = op_a[EXP_W+FRAC_W-1:FRAC_W] == '0;
    assign b_zero   = op_b[EXP_W+FRAC_W-1:FRAC_W] == '0;
    assign any_nan  = a_nan | b_nan;
    assign any_zero = a_zero | b_zero;
    assign res_exp  = result[EXP_W+FRAC_W-1:FRAC_W];

    p_done_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start, 2) |-> done);

    p_no_stray_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start, 2) |-> !done);

    p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_nan_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start, 2) && $past(any_nan, 2)) |-> (result == QNAN));

    p_zero_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start, 2) && !$past(any_nan, 2) && $past(any_zero, 2))
        |-> (result == '0));

    p_zero_positive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_exp == '0) |-> (result == '0));

    p_nan_canonical_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (&res_exp)) |-> (result == QNAN));

endmodule

bind fmul_trunc64 fmul_trunc64_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) chk_i (.*);

// File: tb/fmul_trunc64_tb_top.sv
module fmul_trunc64_tb_top;

    localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        done;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fmul_trunc64 dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_a   (op_a),
        .op_b   (op_b),
        .done   (done),
        .result (result)
    );

    function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
        logic [10:0]  ea, eb;
        logic [105:0] p;
        logic [51:0]  f;
        int           e;
        ea = a[62:52];
        eb = b[62:52];
        if (ea == 11'h7FF || eb == 11'h7FF) return QNAN;
        if (ea == 11'h000 || eb == 11'h000) return 64'h0;
        p = {53'h0, 1'b1, a[51:0]} * {53'h0, 1'b1, b[51:0]};
        if (p[105]) begin
            f = p[104:53];
            e = int'(ea) + int'(eb) - 1022;
        end else begin
            f = p[103:52];
            e = int'(ea) + int'(eb) - 1023;
        end
        if (e <= 0) return 64'h0;
        if (e >= 2047) return QNAN;
        return {a[63] ^ b[63], e[10:0], f};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic run_one(input logic [63:0] a, input logic [63:0] b, input string req);
        logic [63:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        start = 1'b1;
        op_a  = a;
        op_b  = b;
        @(negedge clk);
        start = 1'b0;
        op_a  = $urandom();
        op_b  = $urandom();
        @(negedge clk);
        chk(done === 1'b1, {req, " done"}, {63'h0, done}, 64'h1);
        chk(result === exp, req, result, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
        report();
        $finish;
    end

    initial begin
        logic [63:0] a, b, e1, e2;
        void'($urandom(32'd20517));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(done === 1'b0, "R10 done", {63'h0, done}, 64'h0);
        chk(result === 64'h0, "R10 result", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R10 done after reset", {63'h0, done}, 64'h0);

        // R5 and R6: no shift, and one-bit shift
        run_one(64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R5 1*1");
        chk(result === 64'h3FF0_0000_0000_0000, "R5 1*1 value", result, 64'h3FF0_0000_0000_0000);
        run_one(64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0000, "R6 1.5*1.5");
        chk(result === 64'h4002_0000_0000_0000, "R6 2.25 value", result, 64'h4002_0000_0000_0000);
        // R1: done falls the next cycle, result holds
        @(negedge clk);
        chk(done === 1'b0, "R1 done one cycle", {63'h0, done}, 64'h0);
        chk(result === 64'h4002_0000_0000_0000, "R1 result hold", result, 64'h4002_0000_0000_0000);

        // R4: sign
        run_one(64'hC000_0000_0000_0000, 64'h4008_0000_0000_0000, "R4 -2*3");
        chk(result === 64'hC018_0000_0000_0000, "R4 -6 value", result, 64'hC018_0000_0000_0000);
        run_one(64'hBFF8_0000_0000_0000, 64'hC004_0000_0000_0000, "R4 neg*neg");

        // R7: dropped bits below the ulp do not round up
        run_one(64'h3FF0_0000_0000_0001, 64'h3FFF_FFFF_FFFF_FFFF, "R7 truncate");
        chk(result === 64'h4000_0000_0000_0000, "R7 truncate value", result, 64'h4000_0000_0000_0000);
        run_one(64'h3FFF_FFFF_FFFF_FFFF, 64'h3FFF_FFFF_FFFF_FFFF, "R7 all ones");

        // R2: NaN class, infinity folded in, precedence over zero
        run_one(64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, "R2 inf*0");
        chk(result === QNAN, "R2 inf*0 value", result, QNAN);
        run_one(64'h3FF0_0000_0000_0000, 64'hFFF1_2345_6789_ABCD, "R2 nan operand");
        chk(result === QNAN, "R2 nan value", result, QNAN);

        // R3: zero class, subnormal operand, negative zero operand
        run_one(64'h0000_0000_0000_0001, 64'h3FF0_0000_0000_0000, "R3 subnormal");
        chk(result === 64'h0, "R3 subnormal value", result, 64'h0);
        run_one(64'h8000_0000_0000_0000, 64'hC014_0000_0000_0000, "R3 -0*-5");
        chk(result === 64'h0, "R3 positive zero", result, 64'h0);

        // R8: underflow boundary
        run_one(64'h0010_0000_0000_0000, 64'h3FE0_0000_0000_0000, "R8 exp 0");
        chk(result === 64'h0, "R8 exp 0 value", result, 64'h0);
        run_one(64'h8010_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R8 exp 1 kept");
        chk(result === 64'h8010_0000_0000_0000, "R8 exp 1 value", result, 64'h8010_0000_0000_0000);

        // R9: overflow boundary
        run_one(64'h7FE0_0000_0000_0000, 64'h4000_0000_0000_0000, "R9 exp 2047");
        chk(result === QNAN, "R9 overflow value", result, QNAN);
        run_one(64'h7FE0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R9 exp 2046 kept");
        chk(result === 64'h7FE0_0000_0000_0000, "R9 exp 2046 value", result, 64'h7FE0_0000_0000_0000);

        // R1: back-to-back launches
        a  = 64'h4010_0000_0000_0000;
        b  = 64'hBFF4_0000_0000_0000;
        e1 = ref_mul(a, a);
        e2 = ref_mul(a, b);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = a;
        @(negedge clk);
        op_b = b;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1, "R1 first done", {63'h0, done}, 64'h1);
        chk(result === e1, "R1 first result", result, e1);
        @(negedge clk);
        chk(done === 1'b1, "R1 second done", {63'h0, done}, 64'h1);
        chk(result === e2, "R1 second result", result, e2);
        @(negedge clk);
        chk(done === 1'b0, "R1 idle done", {63'h0, done}, 64'h0);

        // Random mix covering R2..R9
        for (int i = 0; i < 3000; i++) begin
            logic [10:0] xa, xb;
            int sel;
            sel = int'($urandom_range(0, 15));
            xa  = (sel == 0) ? 11'h7FF : (sel == 1) ? 11'h000 : 11'($urandom_range(1, 2046));
            sel = int'($urandom_range(0, 15));
            xb  = (sel == 0) ? 11'h7FF : (sel == 1) ? 11'h000 : 11'($urandom_range(1, 2046));
            a   = {$urandom(), $urandom()};
            b   = {$urandom(), $urandom()};
            a[62:52] = xa;
            b[62:52] = xb;
            run_one(a, b, "R5 R6 R7 random");
        end

        report();
        $finish;
    end

endmodule